// File: doc/BRIEF.md
# Transceiver Bring-Up and Mode Sequencer

This block sits on the host side of a narrow-band radio transceiver. It takes the radio from power-down to a trusted receive state in a fixed order. First it raises the standby pin and waits for the radio's reference clock to settle. Next it drops all three mode pins so the radio is in receive mode, which means nothing can be radiated on a wrong carrier. In that mode it shifts a configuration word out over a three-wire serial port. Last, it waits for the synthesiser to lock before it flags received data as valid.

After bring-up the block acts on a level transmit request. It drives the transmit-enable pin and holds both ready flags low for the receive/transmit turnaround time in either direction. Every wait is a parameter counted in system-clock cycles. The serial clock half-period is also a parameter, and it sets the serial bit rate, which must stay at or below 1 Mbit/s.

States, as named in the RTL: `SQ_OFF` (radio powered down), `SQ_CLKWAIT` (standby, reference settling), `SQ_LOAD` (receive mode, serial transfer), `SQ_SYNTH` (synthesiser lock wait), `SQ_RXRDY` (receive trusted), `SQ_TOTX` (turnaround to transmit), `SQ_TXRDY` (transmit usable), `SQ_TORX` (turnaround to receive). The transitions are:
- OFF→CLKWAIT on start.
- CLKWAIT→LOAD when the timer expires.
- LOAD→SYNTH when the shifter reports done.
- SYNTH→RXRDY when the timer expires.
- RXRDY→TOTX on a transmit request.
- TOTX→TXRDY when the timer expires.
- TXRDY→TORX when the request drops.
- TORX→RXRDY when the timer expires.
- RXRDY or TXRDY→CLKWAIT on start.

Inside the shifter the serial sub-states are `SH_IDLE`, `SH_LEAD`, `SH_LOW`, `SH_HIGH` and `SH_TRAIL`.

Top module: `rfx_bringup_seq`

## Requirements
- R1: After reset the pins are: power-down high, standby low, transmit-enable low. Chip select, serial clock and serial data are all low. Busy and both ready flags are low, and all of these outputs hold until a start pulse arrives.
- R2: The cycle after a start pulse is accepted, busy goes high and the pins become standby high, power-down low, transmit-enable low. This pin state lasts exactly T_CLK_SETTLE cycles.
- R3: After the standby wait, all three mode pins are low for the whole serial transfer and the synthesiser wait. Whenever chip select is high, the mode pins are in receive mode.
- R4: The transfer proceeds in this order:
  - Chip select rises and stays high for 2·SCK_HALF cycles with the serial clock low before the first bit.
  - The 14 bits go out most significant bit first. Each bit takes SCK_HALF cycles low and then SCK_HALF cycles high, with data stable throughout.
  - Data changes only where the serial clock falls.
  - Chip select stays high for 2·SCK_HALF more cycles with the clock low, then falls.
- R5: Consecutive rising edges of the serial clock within one transfer are exactly 2·SCK_HALF system cycles apart.
- R6: The ready flag for received data rises exactly T_SYNTH+1 cycles after chip select falls, and busy falls in that same cycle.
- R7: The word that is shifted out is the one present at the start pulse. Later changes to the word input have no effect on that transfer.
- R8: A start pulse while busy is high is ignored, and the sequence timing continues unchanged.
- R9: A transmit request held during bring-up has no effect on the pins until the receive-ready flag has been high for one cycle. Transmit-enable rises the next cycle.
- R10: On a transmit request in the receive-ready state, transmit-enable goes high and both ready flags go low for exactly T_SWITCH cycles. After that the transmit-ready flag rises.
- R11: When the request drops in the transmit-ready state, transmit-enable goes low and both ready flags go low for exactly T_SWITCH cycles. After that the receive-ready flag rises.
- R12: A start pulse in either ready state restarts the whole sequence from the standby step. The restart takes priority over a transmit request and captures the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the bring-up sequence |
| cfg_word | input | CFG_W | Configuration word, captured at an accepted start |
| tx_req | input | 1 | Level request for transmit mode |
| pwr_down | output | 1 | Radio power-down pin |
| standby | output | 1 | Radio standby pin |
| tx_en | output | 1 | Radio transmit-enable pin |
| ser_cs | output | 1 | Serial chip select, high while loading |
| ser_clk | output | 1 | Serial clock |
| ser_dat | output | 1 | Serial data, most significant bit first |
| busy | output | 1 | High from an accepted start until receive-ready |
| rx_ready | output | 1 | Received data may be trusted |
| tx_ready | output | 1 | Transmit mode is usable |

## Verification
The outputs are Moore functions of registered state, so every response appears in the cycle after the edge that accepted its cause. Standby follows start by one cycle. Chip select rises T_CLK_SETTLE cycles after that. The frame lasts 32·SCK_HALF cycles, receive-ready follows chip select by T_SYNTH+1 cycles, and each turnaround lasts T_SWITCH cycles. The bench keeps a timeline model that records the cycle of each accepted event and derives every expected pin from the offset since that event. It compares all nine outputs on each falling clock edge, half a cycle away from the edges where the design and the stimulus change. A separate measurement of serial clock rising-edge spacing checks the bit rate independently of the model.

// File: rtl/rfx_seq_pkg.sv
package rfx_seq_pkg;

    typedef enum logic [2:0] {
        SQ_OFF,
        SQ_CLKWAIT,
        SQ_LOAD,
        SQ_SYNTH,
        SQ_RXRDY,
        SQ_TOTX,
        SQ_TXRDY,
        SQ_TORX
    } seq_state_t;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_LEAD,
        SH_LOW,
        SH_HIGH,
        SH_TRAIL
    } sh_state_t;

    typedef struct packed {
        logic pwr_down;
        logic standby;
        logic tx_en;
    } mode_pins_t;

    function automatic int unsigned pick_max3(input int unsigned a,
                                              input int unsigned b,
                                              input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rfx_wait_timer.sv
module rfx_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // A load of len makes expired true in the len-th cycle after the load edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/rfx_cfg_shifter.sv
module rfx_cfg_shifter
    import rfx_seq_pkg::*;
#(
    parameter int WORD_W   = 14,
    parameter int SCK_HALF = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [WORD_W-1:0] word,
    output logic              ser_cs,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              done
);

    localparam int GUARD_LEN = 2 * SCK_HALF;
    localparam int HC_W      = $clog2(GUARD_LEN + 1);
    localparam int BI_W      = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    sh_state_t         st, st_nx;
    logic [HC_W-1:0]   hc;
    logic [BI_W-1:0]   bi;
    logic [WORD_W-1:0] sreg;
    logic              guard_end, half_end;

    assign guard_end = (hc == HC_W'(GUARD_LEN - 1));
    assign half_end  = (hc == HC_W'(SCK_HALF - 1));

    always_comb begin
        st_nx = st;
        unique case (st)
            SH_IDLE:  if (launch)    st_nx = SH_LEAD;
            SH_LEAD:  if (guard_end) st_nx = SH_LOW;
            SH_LOW:   if (half_end)  st_nx = SH_HIGH;
            SH_HIGH:  if (half_end)  st_nx = (bi == '0) ? SH_TRAIL : SH_LOW;
            SH_TRAIL: if (guard_end) st_nx = SH_IDLE;
            default:                 st_nx = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= SH_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc   <= '0;
            bi   <= '0;
            sreg <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st_nx != st) begin
                hc <= '0;
            end else if (st != SH_IDLE) begin
                hc <= hc + HC_W'(1);
            end
            unique case (st)
                SH_IDLE: if (launch) sreg <= word;
                SH_LEAD: if (guard_end) bi <= BI_W'(WORD_W - 1);
                SH_HIGH: if (half_end && bi != '0) begin
                    bi   <= bi - BI_W'(1);
                    sreg <= {sreg[WORD_W-2:0], 1'b0};
                end
                SH_TRAIL: if (guard_end) done <= 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        ser_cs  = 1'b0;
        ser_clk = 1'b0;
        ser_dat = 1'b0;
        unique case (st)
            SH_IDLE:  ;
            SH_LEAD,
            SH_TRAIL: ser_cs = 1'b1;
            SH_LOW:   begin ser_cs = 1'b1; ser_dat = sreg[WORD_W-1]; end
            SH_HIGH:  begin ser_cs = 1'b1; ser_clk = 1'b1; ser_dat = sreg[WORD_W-1]; end
            default:  ;
        endcase
    end

    // R4
    clk_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> ser_cs);

    // R4
    dat_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

    // R4
    dat_change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_cs && $past(ser_cs) && !$stable(ser_dat)) |-> $fell(ser_clk) || !ser_clk);

endmodule

// File: rtl/rfx_bringup_seq.sv
module rfx_bringup_seq
    import rfx_seq_pkg::*;
#(
    parameter int CFG_W        = 14,
    parameter int SCK_HALF     = 8,
    parameter int T_CLK_SETTLE = 14400,
    parameter int T_SYNTH      = 65600,
    parameter int T_SWITCH     = 24000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             tx_req,
    output logic             pwr_down,
    output logic             standby,
    output logic             tx_en,
    output logic             ser_cs,
    output logic             ser_clk,
    output logic             ser_dat,
    output logic             busy,
    output logic             rx_ready,
    output logic             tx_ready
);

    localparam int T_MAX = int'(pick_max3(T_CLK_SETTLE, T_SYNTH, T_SWITCH));
    localparam int TW    = $clog2(T_MAX + 1);

    seq_state_t       state, state_nx;
    logic             tmr_load, tmr_done;
    logic [TW-1:0]    tmr_len;
    logic             sh_launch, sh_done;
    logic             cap_word;
    logic [CFG_W-1:0] cfg_q;
    mode_pins_t       pins;

    rfx_wait_timer #(.CNT_W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_done)
    );

    rfx_cfg_shifter #(.WORD_W(CFG_W), .SCK_HALF(SCK_HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (sh_launch),
        .word    (cfg_q),
        .ser_cs  (ser_cs),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .done    (sh_done)
    );

    always_comb begin
        state_nx  = state;
        tmr_load  = 1'b0;
        tmr_len   = TW'(T_SWITCH);
        sh_launch = 1'b0;
        cap_word  = 1'b0;
        unique case (state)
            SQ_OFF: if (start) begin
                state_nx = SQ_CLKWAIT;
                tmr_load = 1'b1;
                tmr_len  = TW'(T_CLK_SETTLE);
                cap_word = 1'b1;
            end
            SQ_CLKWAIT: if (tmr_done) begin
                state_nx  = SQ_LOAD;
                sh_launch = 1'b1;
            end
            SQ_LOAD: if (sh_done) begin
                state_nx = SQ_SYNTH;
                tmr_load = 1'b1;
                tmr_len  = TW'(T_SYNTH);
            end
            SQ_SYNTH: if (tmr_done) state_nx = SQ_RXRDY;
            SQ_RXRDY: if (start) begin
                state_nx = SQ_CLKWAIT;
                tmr_load = 1'b1;
                tmr_len  = TW'(T_CLK_SETTLE);
                cap_word = 1'b1;
            end else if (tx_req) begin
                state_nx = SQ_TOTX;
                tmr_load = 1'b1;
            end
            SQ_TOTX: if (tmr_done) state_nx = SQ_TXRDY;
            SQ_TXRDY: if (start) begin
                state_nx = SQ_CLKWAIT;
                tmr_load = 1'b1;
                tmr_len  = TW'(T_CLK_SETTLE);
                cap_word = 1'b1;
            end else if (!tx_req) begin
                state_nx = SQ_TORX;
                tmr_load = 1'b1;
            end
            SQ_TORX: if (tmr_done) state_nx = SQ_RXRDY;
            default: state_nx = SQ_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SQ_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cap_word) begin
            cfg_q <= cfg_word;
        end
    end

    always_comb begin
        pins     = '{pwr_down: 1'b0, standby: 1'b0, tx_en: 1'b0};
        busy     = 1'b0;
        rx_ready = 1'b0;
        tx_ready = 1'b0;
        unique case (state)
            SQ_OFF:     pins.pwr_down = 1'b1;
            SQ_CLKWAIT: begin pins.standby = 1'b1; busy = 1'b1; end
            SQ_LOAD,
            SQ_SYNTH:   busy = 1'b1;
            SQ_RXRDY:   rx_ready = 1'b1;
            SQ_TOTX:    pins.tx_en = 1'b1;
            SQ_TXRDY:   begin pins.tx_en = 1'b1; tx_ready = 1'b1; end
            SQ_TORX:    ;
            default:    pins.pwr_down = 1'b1;
        endcase
    end

    assign pwr_down = pins.pwr_down;
    assign standby  = pins.standby;
    assign tx_en    = pins.tx_en;

    // R3
    load_in_rx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_cs |-> (!pwr_down && !standby && !tx_en));

    // R9
    no_tx_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tx_en);

    // R6
    busy_ends_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rx_ready);

    // R10
    ready_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_ready, tx_ready}));

    // R10
    tx_ready_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_en);

    // R8
    start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !standby) |=> !standby);

endmodule

// File: tb/sim_rfx_bringup_seq.sv
`timescale 1ns/1ps
module sim_rfx_bringup_seq;

    localparam int W    = 14;
    localparam int H    = 2;
    localparam int TCLK = 20;
    localparam int TSYN = 30;
    localparam int TSW  = 12;
    localparam int FRM  = 32 * H;
    localparam int LBR  = TCLK + FRM + 1 + TSYN;

    localparam int M_OFF = 0, M_BRING = 1, M_RXR = 2, M_TOTX = 3, M_TXR = 4, M_TORX = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] cfg_word = '0;
    logic tx_req = 1'b0;
    logic pwr_down, standby, tx_en, ser_cs, ser_clk, ser_dat, busy, rx_ready, tx_ready;

    always #4 clk = ~clk;

    rfx_bringup_seq #(.CFG_W(W), .SCK_HALF(H), .T_CLK_SETTLE(TCLK),
                      .T_SYNTH(TSYN), .T_SWITCH(TSW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word), .tx_req(tx_req),
        .pwr_down(pwr_down), .standby(standby), .tx_en(tx_en),
        .ser_cs(ser_cs), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .busy(busy), .rx_ready(rx_ready), .tx_ready(tx_ready)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int t0 = 0;
    int m_mode = M_OFF;
    logic [W-1:0] m_word = '0;
    string focus = "R1";
    int last_rise = -1;
    logic prev_sck = 1'b0;

    // Timeline model: records when each accepted event happened.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            m_mode = M_OFF;
        end else begin
            case (m_mode)
                M_OFF:   if (start) begin m_mode = M_BRING; t0 = cyc; m_word = cfg_word; end
                M_BRING: if (cyc - t0 == LBR) m_mode = M_RXR;
                M_RXR:   if (start) begin m_mode = M_BRING; t0 = cyc; m_word = cfg_word; end
                         else if (tx_req) begin m_mode = M_TOTX; t0 = cyc; end
                M_TOTX:  if (cyc - t0 == TSW) m_mode = M_TXR;
                M_TXR:   if (start) begin m_mode = M_BRING; t0 = cyc; m_word = cfg_word; end
                         else if (!tx_req) begin m_mode = M_TORX; t0 = cyc; end
                M_TORX:  if (cyc - t0 == TSW) m_mode = M_RXR;
                default: m_mode = M_OFF;
            endcase
        end
    end

    // Order: pd, stby, txen, cs, sck, dat, busy, rxr, txr
    function automatic logic [8:0] expect_pins(output string tag);
        int k, j, b, s;
        logic [8:0] e;
        k = cyc - t0;
        e = '0;
        tag = "R1";
        case (m_mode)
            M_OFF: e[8] = 1'b1;
            M_BRING: begin
                e[2] = 1'b1;
                if (k < TCLK) begin
                    e[7] = 1'b1; tag = "R2";
                end else if (k < TCLK + FRM) begin
                    tag = "R4";
                    e[5] = 1'b1;
                    j = k - TCLK;
                    if (j >= 2 * H && j < 30 * H) begin
                        b = (j - 2 * H) / (2 * H);
                        s = (j - 2 * H) % (2 * H);
                        e[4] = (s >= H);
                        e[3] = m_word[W - 1 - b];
                    end
                end else begin
                    tag = "R3";
                end
            end
            M_RXR:  begin e[1] = 1'b1; tag = "R6"; end
            M_TOTX: begin e[6] = 1'b1; tag = "R10"; end
            M_TXR:  begin e[6] = 1'b1; e[0] = 1'b1; tag = "R10"; end
            M_TORX: tag = "R11";
            default: ;
        endcase
        return e;
    endfunction

    always @(negedge clk) begin
        logic [8:0] act, exp_v;
        string tag;
        act   = {pwr_down, standby, tx_en, ser_cs, ser_clk, ser_dat, busy, rx_ready, tx_ready};
        exp_v = expect_pins(tag);
        n_checks++;
        if (act !== exp_v) begin
            n_errors++;
            $display("FAIL %s (scenario %s) cycle %0d: actual=%b expected=%b",
                     tag, focus, cyc, act, exp_v);
        end
        // R5: spacing of serial clock rising edges inside one frame
        if (!ser_cs) last_rise = -1;
        else if (ser_clk && !prev_sck) begin
            if (last_rise >= 0) begin
                n_checks++;
                if (cyc - last_rise != 2 * H) begin
                    n_errors++;
                    $display("FAIL R5 rise spacing: actual=%0d expected=%0d",
                             cyc - last_rise, 2 * H);
                end
            end
            last_rise = cyc;
        end
        prev_sck = ser_clk;
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_mode(input int m);
        while (m_mode != m) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // R1: reset and idle state
        focus = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(5);

        // R2, R3, R4, R7, R8, R9: bring-up with disturbances
        focus = "R7";
        cfg_word = 14'h2D69;
        pulse_start();
        cfg_word = 14'h1111;          // R7: must not reach the wire
        idle(40);
        focus = "R8";
        pulse_start();                // R8: ignored while busy
        idle(10);
        focus = "R9";
        tx_req = 1'b1;                // R9: held until receive-ready
        wait_mode(M_TXR);
        idle(4);
        focus = "R11";
        tx_req = 1'b0;
        wait_mode(M_RXR);
        idle(5);

        // R12: restart from receive-ready with an all-ones word
        focus = "R12";
        cfg_word = 14'h3FFF;
        pulse_start();
        wait_mode(M_RXR);
        idle(3);
        focus = "R10";
        tx_req = 1'b1;
        wait_mode(M_TXR);
        idle(3);
        // R12: restart from transmit-ready, priority over the request
        focus = "R12";
        cfg_word = 14'h0001;
        tx_req = 1'b0;
        pulse_start();
        wait_mode(M_RXR);
        idle(4);

        // Alternating pattern, start and request together in receive-ready
        focus = "R12";
        cfg_word = 14'h2AAA;
        tx_req = 1'b1;
        pulse_start();
        tx_req = 1'b0;
        wait_mode(M_RXR);
        idle(6);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule